// File: doc/BRIEF.md
# Twelve-Hour Clock Counter Chain

This block keeps the time of day for a twelve-hour clock. A one-cycle `tick` enable, asserted once per second by an external divider, advances a chain of synchronous counters. Seconds and minutes are each held as a units digit that counts 0 to 9 and a tens digit that counts 0 to 5. Hours run 12, 1, 2, ... 11, 12, and a half-day flag marks the afternoon. All digits come out as BCD for a display driver further down the chip.

Every counter shares one clock. A stage advances the stage above it by watching the top bit that changes on its own wrap: bit 3 of a decade digit, bit 2 of a mod-6 digit. When that bit falls, the stage emits a one-cycle enable pulse. The hours field counts its units digit freely. It sees the value 13 coming and loads 01 in its place, so 13 never appears on the outputs. `tick` may be asserted on any number of consecutive cycles. Each stage adds one clock of delay before the next stage moves.

Top module: `clk12_chain`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs go to 12:00:00 with `pm` low: hours tens 1, hours units 2, all other digits 0.
- R2: `sec_ones` counts 0 to 9 in BCD. Each edge with `tick` high adds one, 9 wraps to 0, and an edge with `tick` low leaves it unchanged.
- R3: `sec_tens` and `min_tens` stay in the range 0 to 5. Bit 3 of these outputs is always 0, and 5 wraps to 0.
- R4: When bit 3 of `sec_ones` falls (the 9-to-0 wrap), `sec_tens` advances at the next clock edge. This is exactly one cycle after the wrap.
- R5: When bit 2 of `sec_tens` falls (the 5-to-0 wrap), `min_ones` advances one edge later. Minutes form the same decade plus mod-6 pair as seconds, and bit 2 of `min_tens` falling advances the hours one edge later.
- R6: Hours step 12, 1, 2, ..., 11, 12. `hr_tens` is one bit. The step from 9 to 10 changes both hour digits at the same edge. The value 13 is replaced by 01, and the hours never show 0 or any value above 12.
- R7: `pm` toggles exactly when the hours move from 11 to 12 and never changes otherwise. This makes 11:59:59 AM followed by 12:00:00 PM, and 11:59:59 PM followed by 12:00:00 AM.
- R8: Once the carries have settled, N ticks after reset the outputs show the time N seconds after 12:00:00 AM, taken modulo 24 hours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every counter |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second advance enable |
| sec_ones | output | 4 | Seconds units digit, BCD |
| sec_tens | output | 4 | Seconds tens digit, BCD 0..5 |
| min_ones | output | 4 | Minutes units digit, BCD |
| min_tens | output | 4 | Minutes tens digit, BCD 0..5 |
| hr_tens | output | 1 | Hours tens digit |
| hr_ones | output | 4 | Hours units digit, BCD |
| pm | output | 1 | High for afternoon hours |

## Verification
The hardest events to reach are the 11-to-12 hour step that flips `pm` and the 12-to-1 preset. There is no load port, so each of them comes only after tens of thousands of seconds of counting. The bench starts with randomly sized and spaced tick bursts, which put the counters at an arbitrary phase. It then asserts `tick` on every clock until the counters reach 11:59:59 in both halves of the day and also the top of each relevant hour. The exact one-cycle carry delay is probed directly by sampling every cycle after a 59-second wrap.

// File: rtl/clk12_pkg.sv
package clk12_pkg;

    localparam int DIGIT_W     = 4;
    localparam int N_LOW       = 4;   // sec units, sec tens, min units, min tens
    localparam int DECADE_MOD  = 10;
    localparam int SEXT_MOD    = 6;
    localparam int HOUR_UNITS_WRAP = 9;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        logic   pm;
        logic   hr_tens;
        digit_t hr_ones;
    } hours_t;

    localparam hours_t HOURS_AT_RESET = '{pm: 1'b0, hr_tens: 1'b1, hr_ones: 4'd2};

    // Even stages are decade digits, odd stages are mod-6 digits.
    function automatic int stage_modulus(input int idx);
        return (idx % 2 == 0) ? DECADE_MOD : SEXT_MOD;
    endfunction

    // Highest bit that changes on the wrap of a stage.
    function automatic int stage_carry_bit(input int idx);
        return (idx % 2 == 0) ? 3 : 2;
    endfunction

    function automatic digit_t wrap_inc(input digit_t d, input int modulus);
        return (d == digit_t'(modulus - 1)) ? '0 : d + 1'b1;
    endfunction

    function automatic logic fell(input logic was, input logic now);
        return was & ~now;
    endfunction

    function automatic logic is_hour(input hours_t h, input logic t, input digit_t u);
        return (h.hr_tens == t) && (h.hr_ones == u);
    endfunction

    // Next hour value: units count with a carry into the single tens bit,
    // then the state tens=1 units=3 is replaced by 01.
    function automatic hours_t hours_next(input hours_t h);
        hours_t n;
        n = h;
        if (h.hr_ones == digit_t'(HOUR_UNITS_WRAP)) begin
            n.hr_ones = '0;
            n.hr_tens = 1'b1;
        end else begin
            n.hr_ones = h.hr_ones + 1'b1;
        end
        if (is_hour(n, 1'b1, 4'd3)) begin
            n.hr_tens = 1'b0;
            n.hr_ones = 4'd1;
        end
        if (is_hour(h, 1'b1, 4'd1)) begin
            n.pm = ~h.pm;
        end
        return n;
    endfunction

endpackage

// File: rtl/clk12_digit.sv
module clk12_digit
    import clk12_pkg::*;
#(
    parameter int MODULUS   = 10,
    parameter int CARRY_BIT = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output digit_t q,
    output logic   carry
);
    logic top_was;

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            top_was <= 1'b0;
        end else begin
            if (adv) begin
                q <= wrap_inc(q, MODULUS);
            end
            top_was <= q[CARRY_BIT];
        end
    end

    // High for the one cycle after the watched bit falls.
    assign carry = fell(top_was, q[CARRY_BIT]);

endmodule

// File: rtl/clk12_hours.sv
module clk12_hours
    import clk12_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output hours_t hrs
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hrs <= HOURS_AT_RESET;
        end else if (adv) begin
            hrs <= hours_next(hrs);
        end
    end
endmodule

// File: rtl/clk12_chain.sv
module clk12_chain
    import clk12_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    output logic [3:0] sec_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] min_ones,
    output logic [3:0] min_tens,
    output logic       hr_tens,
    output logic [3:0] hr_ones,
    output logic       pm
);
    logic [N_LOW:0] adv_chain;
    digit_t         digits [N_LOW];
    hours_t         hrs;

    assign adv_chain[0] = tick;

    for (genvar i = 0; i < N_LOW; i++) begin : g_stage
        clk12_digit #(
            .MODULUS  (stage_modulus(i)),
            .CARRY_BIT(stage_carry_bit(i))
        ) u_stage (
            .clk  (clk),
            .rst  (rst),
            .adv  (adv_chain[i]),
            .q    (digits[i]),
            .carry(adv_chain[i+1])
        );
    end

    clk12_hours u_hours (
        .clk(clk),
        .rst(rst),
        .adv(adv_chain[N_LOW]),
        .hrs(hrs)
    );

    assign sec_ones = digits[0];
    assign sec_tens = digits[1];
    assign min_ones = digits[2];
    assign min_tens = digits[3];
    assign hr_tens  = hrs.hr_tens;
    assign hr_ones  = hrs.hr_ones;
    assign pm       = hrs.pm;

endmodule

// File: rtl/clk12_chk.sv
module clk12_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [3:0] sec_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] min_ones,
    input logic [3:0] min_tens,
    input logic       hr_tens,
    input logic [3:0] hr_ones,
    input logic       pm
);
    logic is12, is11;
    assign is12 = hr_tens && (hr_ones == 4'd2);
    assign is11 = hr_tens && (hr_ones == 4'd1);

    AST_RESET_VALUE: assert property (@(posedge clk)
        rst |=> (sec_ones == 0 && sec_tens == 0 && min_ones == 0 && min_tens == 0 && is12 && !pm)); // R1
    AST_UNITS_RANGE: assert property (@(posedge clk) disable iff (rst)
        sec_ones <= 4'd9 && min_ones <= 4'd9); // R2
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> sec_ones == (($past(sec_ones) == 4'd9) ? 4'd0 : $past(sec_ones) + 4'd1)); // R2
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sec_ones)); // R2
    AST_TENS_RANGE: assert property (@(posedge clk) disable iff (rst)
        sec_tens <= 4'd5 && min_tens <= 4'd5); // R3
    AST_SEC_CARRY: assert property (@(posedge clk) disable iff (rst)
        $fell(sec_ones[3]) |=> !$stable(sec_tens)); // R4
    AST_MIN_CARRY: assert property (@(posedge clk) disable iff (rst)
        $fell(sec_tens[2]) |=> !$stable(min_ones)); // R5
    AST_HOURS_VALID: assert property (@(posedge clk) disable iff (rst)
        (!hr_tens && hr_ones != 0 && hr_ones <= 4'd9) || (hr_tens && hr_ones <= 4'd2)); // R6
    AST_HOUR_PRESET: assert property (@(posedge clk) disable iff (rst)
        ($past(is12) && !is12) |-> (!hr_tens && hr_ones == 4'd1)); // R6
    AST_PM_ONLY_AT_NOON: assert property (@(posedge clk) disable iff (rst)
        !$stable(pm) |-> (is12 && $past(is11))); // R7
endmodule

bind clk12_chain clk12_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick),
    .sec_ones(sec_ones), .sec_tens(sec_tens),
    .min_ones(min_ones), .min_tens(min_tens),
    .hr_tens(hr_tens), .hr_ones(hr_ones), .pm(pm)
);

// File: tb/tb_clk12_chain.sv
`timescale 1ns/1ps
module tb_clk12_chain;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones;
    logic hr_tens, pm;

    int checks = 0;
    int errors = 0;
    int nticks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    clk12_chain dut (.*);

    // {pm, hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones}
    function automatic logic [21:0] expect_time(input int n);
        int t, h;
        logic [21:0] r;
        t = n % 86400;
        h = (t / 3600) % 12;
        if (h == 0) h = 12;
        r = {t >= 43200 ? 1'b1 : 1'b0, h >= 10 ? 1'b1 : 1'b0, 4'(h % 10),
             4'((t / 600) % 6), 4'((t / 60) % 10), 4'((t % 60) / 10), 4'(t % 10)};
        return r;
    endfunction

    function automatic logic [21:0] shown();
        return {pm, hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};
    endfunction

    task automatic check(input string req, input logic [21:0] got, input logic [21:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk) tick = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_time(input string req);
        check(req, shown(), expect_time(nticks));
    endtask

    // Ticks on consecutive cycles; hour validity checked on every cycle (R6).
    task automatic run_to(input int target);
        int need;
        need = (target - (nticks % 86400) + 86400) % 86400;
        for (int i = 0; i < need; i++) begin
            @(negedge clk);
            if (!((!hr_tens && hr_ones != 0 && hr_ones <= 9) || (hr_tens && hr_ones <= 2)))
                check("R6 hour range", {hr_tens, hr_ones}, 5'h12);
            tick = 1'b1;
            nticks++;
        end
        settle();
    endtask

    task automatic one_tick();
        @(negedge clk) tick = 1'b1;
        nticks++;
        settle();
    endtask

    initial begin
        void'($urandom(32'h1C0C));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset 12:00:00 AM", shown(), {1'b0, 1'b1, 4'd2, 16'h0});

        repeat (20) @(negedge clk);
        check("R2 idle hold", shown(), expect_time(0));

        // Directed carry timing around a 59-second wrap.
        run_to(59);
        check_time("R2 count to 59");
        @(negedge clk) tick = 1'b1; nticks++;
        @(negedge clk) tick = 1'b0;
        check("R4 units wrapped, tens still 5", {sec_tens, sec_ones}, 8'h50);
        @(negedge clk);
        check("R4 tens follows one cycle later", {sec_tens, sec_ones}, 8'h00);
        check("R5 minutes not yet", min_ones, 4'd0);
        @(negedge clk);
        check("R5 minute units advance", min_ones, 4'd1);
        settle();
        check_time("R5 01:00 settled");

        // Random bursts with random gaps.
        for (int k = 0; k < 250; k++) begin
            int len;
            len = $urandom_range(1, 40);
            for (int j = 0; j < len; j++) begin
                @(negedge clk);
                tick = 1'b1;
                nticks++;
                if ($urandom_range(0, 3) == 0) begin
                    @(negedge clk) tick = 1'b0;
                end
            end
            settle();
            check_time("R8 random bursts");
            if (sec_tens > 5 || min_tens > 5) check("R3 tens range", {sec_tens, min_tens}, 8'h55);
        end

        run_to(9 * 3600 + 3599);
        check_time("R6 09:59:59");
        one_tick();
        check("R6 nine to ten", {hr_tens, hr_ones}, 5'h10);
        run_to(43199);
        check("R7 11:59:59 AM", shown(), {1'b0, 1'b1, 4'd1, 16'h5959});
        one_tick();
        check("R7 noon is PM", shown(), {1'b1, 1'b1, 4'd2, 16'h0000});
        run_to(43200 + 3599);
        check_time("R6 12:59:59 PM");
        one_tick();
        check("R6 twelve to one", shown(), {1'b1, 1'b0, 4'd1, 16'h0000});
        run_to(86399);
        check("R7 11:59:59 PM", shown(), {1'b1, 1'b1, 4'd1, 16'h5959});
        one_tick();
        check("R7 midnight is AM", shown(), {1'b0, 1'b1, 4'd2, 16'h0000});
        run_to(3 * 3600 + 1234);
        check_time("R8 after full day");

        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nticks = 0;
        @(negedge clk);
        check("R1 reset mid-run", shown(), {1'b0, 1'b1, 4'd2, 16'h0});

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule